// File: doc/BRIEF.md
# Cascaded Compare Timer with Split and 12-bit Modes

The block is a timer built from two up-counting stages: a narrow low stage (4 bits by default) and a wider high stage (8 bits by default). Each stage owns a compare register. Depending on the selected mode, the stages either join into one 12-bit counter compared against a value assembled from both registers, or run as two separate counter/comparator pairs. In one of the separate modes the low stage's match pulse is the only thing that advances the high stage, so the pair forms a two-level divider.

Match pulses are registered, one clock wide, and drive three consumers: the two match outputs, an interrupt request pulse, and a toggle flip-flop whose output serves as a serial shift clock. A global enable gates all counting. A compare register written in the same cycle as its stage would match cancels that match pulse, so software can retune the period without a spurious event.

Mode encoding on `mode`: 0 selects the joined 12-bit mode, 1 selects the chained mode (high stage advanced by low-stage pulses), 2 and 3 both select free-running split mode (both stages advance on every enabled cycle).

Top module: `cascade_cmp_timer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `cnt_lo`, `cnt_hi`, `match_lo`, `match_hi`, `irq` and `shift_clk` are 0, and both compare registers hold all ones (4'hF and 8'hFF).
- R2: In split mode (`mode` 2 or 3) with `en` high, each stage counts up by one per cycle; a stage whose count equals its compare value reloads to 0 at the next edge and, at that same edge, raises its match output (`match_lo` or `match_hi`) for exactly one cycle, giving a period of compare value plus one cycles.
- R3: While `en` is low, both counters keep their values and no match, `irq` or toggle event is produced.
- R4: In chained mode (`mode` 1) the low stage counts every enabled cycle as in R2, and the high stage advances by exactly one (with its own compare and reload) only at edges where a low-stage match pulse is issued.
- R5: In 12-bit mode (`mode` 0) the value {`cnt_hi`,`cnt_lo`} counts up by one per enabled cycle, wrapping from 4095 to 0; when it equals {high compare, low compare} it reloads to 0 and `match_hi` pulses; `match_lo` stays 0 throughout this mode.
- R6: A write to a compare register in the cycle a match on that register would be issued suppresses the match pulse (and its `irq`, toggle and chaining effects) while the counter still reloads to 0; in 12-bit mode a write to either register suppresses the 12-bit match.
- R7: `shift_clk` inverts at each issued low-stage match in modes 1 to 3, and at each issued 12-bit match in mode 0, and at no other time.
- R8: `irq` pulses together with `match_hi` in modes 0 and 1, and together with either match output in modes 2 and 3; it never pulses without a match output.
- R9: With `wr_en` high, `wr_sel` 0 loads `wr_data[3:0]` into the low compare register (upper data bits ignored) and `wr_sel` 1 loads all 8 bits into the high compare register; the new value is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Count enable |
| mode | input | 2 | 0 joined 12-bit, 1 chained, 2/3 free split |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 1 | 0 selects low compare, 1 selects high compare |
| wr_data | input | 8 | Write data |
| cnt_lo | output | 4 | Low stage count |
| cnt_hi | output | 8 | High stage count |
| match_lo | output | 1 | Low stage match pulse |
| match_hi | output | 1 | High stage or 12-bit match pulse |
| irq | output | 1 | Interrupt request pulse |
| shift_clk | output | 1 | Toggle flip-flop output used as shift clock |

## Verification
The hardest situation to reach is a compare write landing in exactly the cycle a stage sits on its compare value, since that window is one enabled cycle per period. The bench keeps its own behavioural copy of the counts, waits until that copy shows the stage on its compare value, and only then issues the write (rewriting the same value so the period stays predictable). This is repeated for the low stage, the high stage and the joined 12-bit count, and each time the bench confirms that the pulse is missing while the counter has still returned to zero.

// File: rtl/ct_pkg.sv
package ct_pkg;

    typedef enum logic [1:0] {
        CT_JOINED  = 2'd0,
        CT_CHAINED = 2'd1,
        CT_SPLIT   = 2'd2,
        CT_SPLIT_B = 2'd3
    } ct_mode_e;

    typedef struct packed {
        logic lo;
        logic hi;
        logic irq;
        logic tgl;
    } ct_out_t;

endpackage

// File: rtl/ct_cmp_regs.sv
module ct_cmp_regs #(
    parameter int LO_W = 4,
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [HI_W-1:0] wr_data,
    output logic [LO_W-1:0] cmp_lo,
    output logic [HI_W-1:0] cmp_hi,
    output logic            sup_lo,
    output logic            sup_hi
);

    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_sel) begin
                regs_d.hi = wr_data;
            end else begin
                regs_d.lo = wr_data[LO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.lo <= '1;
            regs_q.hi <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cmp_lo = regs_q.lo;
    assign cmp_hi = regs_q.hi;
    assign sup_lo = wr_en & ~wr_sel;
    assign sup_hi = wr_en & wr_sel;

endmodule

// File: rtl/ct_stage.sv
module ct_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         reload,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         eq,
    output logic         at_max
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (reload) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign eq     = (st_q.cnt == cmp);
    assign at_max = &st_q.cnt;

endmodule

// File: rtl/ct_match_logic.sv
module ct_match_logic
    import ct_pkg::*;
(
    input  ct_mode_e mode,
    input  logic     en,
    input  logic     eq_lo,
    input  logic     eq_hi,
    input  logic     max_lo,
    input  logic     sup_lo,
    input  logic     sup_hi,
    output logic     step_lo,
    output logic     reload_lo,
    output logic     step_hi,
    output logic     reload_hi,
    output logic     fire_lo,
    output logic     fire_hi,
    output logic     fire_irq,
    output logic     fire_tgl
);

    logic joined;
    logic chained;
    logic split;
    logic both_eq;
    logic fire_joined;

    always_comb begin
        joined  = (mode == CT_JOINED);
        chained = (mode == CT_CHAINED);
        split   = (mode == CT_SPLIT) || (mode == CT_SPLIT_B);
        both_eq = eq_lo & eq_hi;

        step_lo   = en;
        reload_lo = joined ? both_eq : eq_lo;

        fire_lo     = en & ~joined & eq_lo & ~sup_lo;
        fire_joined = en & joined & both_eq & ~(sup_lo | sup_hi);

        if (joined) begin
            step_hi = en & (both_eq | max_lo);
        end else if (chained) begin
            step_hi = fire_lo;
        end else begin
            step_hi = en;
        end
        reload_hi = joined ? both_eq : eq_hi;

        fire_hi  = joined ? fire_joined : (step_hi & eq_hi & ~sup_hi);
        fire_irq = split ? (fire_lo | fire_hi) : fire_hi;
        fire_tgl = joined ? fire_hi : fire_lo;
    end

endmodule

// File: rtl/ct_out_regs.sv
module ct_out_regs
    import ct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_lo,
    input  logic fire_hi,
    input  logic fire_irq,
    input  logic fire_tgl,
    output logic match_lo,
    output logic match_hi,
    output logic irq,
    output logic tgl
);

    ct_out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.lo  = fire_lo;
        out_d.hi  = fire_hi;
        out_d.irq = fire_irq;
        out_d.tgl = out_q.tgl ^ fire_tgl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign match_lo = out_q.lo;
    assign match_hi = out_q.hi;
    assign irq      = out_q.irq;
    assign tgl      = out_q.tgl;

endmodule

// File: rtl/cascade_cmp_timer.sv
module cascade_cmp_timer
    import ct_pkg::*;
#(
    parameter int LO_W = 4,
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [1:0]      mode,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [HI_W-1:0] wr_data,
    output logic [LO_W-1:0] cnt_lo,
    output logic [HI_W-1:0] cnt_hi,
    output logic            match_lo,
    output logic            match_hi,
    output logic            irq,
    output logic            shift_clk
);

    logic [LO_W-1:0] cmp_lo;
    logic [HI_W-1:0] cmp_hi;
    logic            sup_lo, sup_hi;
    logic            eq_lo, eq_hi, max_lo, max_hi;
    logic            step_lo, reload_lo, step_hi, reload_hi;
    logic            fire_lo, fire_hi, fire_irq, fire_tgl;
    ct_mode_e        mode_e;

    assign mode_e = ct_mode_e'(mode);

    ct_cmp_regs #(.LO_W(LO_W), .HI_W(HI_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cmp_lo  (cmp_lo),
        .cmp_hi  (cmp_hi),
        .sup_lo  (sup_lo),
        .sup_hi  (sup_hi)
    );

    ct_stage #(.W(LO_W)) u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step_lo),
        .reload (reload_lo),
        .cmp    (cmp_lo),
        .cnt    (cnt_lo),
        .eq     (eq_lo),
        .at_max (max_lo)
    );

    ct_stage #(.W(HI_W)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step_hi),
        .reload (reload_hi),
        .cmp    (cmp_hi),
        .cnt    (cnt_hi),
        .eq     (eq_hi),
        .at_max (max_hi)
    );

    ct_match_logic u_match (
        .mode      (mode_e),
        .en        (en),
        .eq_lo     (eq_lo),
        .eq_hi     (eq_hi),
        .max_lo    (max_lo),
        .sup_lo    (sup_lo),
        .sup_hi    (sup_hi),
        .step_lo   (step_lo),
        .reload_lo (reload_lo),
        .step_hi   (step_hi),
        .reload_hi (reload_hi),
        .fire_lo   (fire_lo),
        .fire_hi   (fire_hi),
        .fire_irq  (fire_irq),
        .fire_tgl  (fire_tgl)
    );

    ct_out_regs u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_lo  (fire_lo),
        .fire_hi  (fire_hi),
        .fire_irq (fire_irq),
        .fire_tgl (fire_tgl),
        .match_lo (match_lo),
        .match_hi (match_hi),
        .irq      (irq),
        .tgl      (shift_clk)
    );

    logic unused_max_hi;
    assign unused_max_hi = max_hi;

endmodule

// File: rtl/ct_timer_checker.sv
module ct_timer_checker #(
    parameter int LO_W = 4,
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic [1:0]      mode,
    input logic            wr_en,
    input logic            wr_sel,
    input logic [LO_W-1:0] cnt_lo,
    input logic [HI_W-1:0] cnt_hi,
    input logic            match_lo,
    input logic            match_hi,
    input logic            irq,
    input logic            shift_clk
);

    AST_MATCH_LO_RELOADED: assert property (@(posedge clk) disable iff (!rst_n)
        match_lo |-> (cnt_lo == '0)); // R2
    AST_MATCH_HI_RELOADED: assert property (@(posedge clk) disable iff (!rst_n)
        match_hi |-> (cnt_hi == '0)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!match_lo && !match_hi && !irq && $stable(cnt_lo) && $stable(cnt_hi))); // R3
    AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |=> ($stable(cnt_hi) || match_lo)); // R4
    AST_JOINED_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> !match_lo); // R5
    AST_SUPPRESS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> !match_lo); // R6
    AST_SUPPRESS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel || mode == 2'd0)) |=> !match_hi); // R6
    AST_TOGGLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shift_clk) |-> (match_lo || match_hi)); // R7
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match_lo || match_hi)); // R8

endmodule

bind cascade_cmp_timer ct_timer_checker #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mode      (mode),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .match_lo  (match_lo),
    .match_hi  (match_hi),
    .irq       (irq),
    .shift_clk (shift_clk)
);

// File: tb/cascade_cmp_timer_test.sv
`timescale 1ns/1ps
module cascade_cmp_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode = 2'd2;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] cnt_lo;
    logic [7:0] cnt_hi;
    logic       match_lo, match_hi, irq, shift_clk;

    always #2.5 clk = ~clk;

    cascade_cmp_timer uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .match_lo(match_lo),
        .match_hi(match_hi), .irq(irq), .shift_clk(shift_clk)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    int m_a, m_b, m_ca, m_cb, m_lo, m_hi, m_irq, m_tgl;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int sa, sb, full, cmpf, ha, hb, stepb;
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_ca = 15; m_cb = 255;
            m_lo = 0; m_hi = 0; m_irq = 0; m_tgl = 0;
            return;
        end
        sa = (wr_en && !wr_sel) ? 1 : 0;
        sb = (wr_en && wr_sel) ? 1 : 0;
        m_lo = 0; m_hi = 0;
        if (en) begin
            if (mode == 2'd0) begin
                full = m_b * 16 + m_a;
                cmpf = m_cb * 16 + m_ca;
                if (full == cmpf) begin
                    m_hi = (sa == 0 && sb == 0) ? 1 : 0;
                    full = 0;
                end else begin
                    full = (full + 1) % 4096;
                end
                m_a = full % 16;
                m_b = full / 16;
            end else begin
                ha = (m_a == m_ca) ? 1 : 0;
                m_lo = (ha == 1 && sa == 0) ? 1 : 0;
                m_a = ha ? 0 : (m_a + 1) % 16;
                stepb = (mode == 2'd1) ? m_lo : 1;
                if (stepb == 1) begin
                    hb = (m_b == m_cb) ? 1 : 0;
                    m_hi = (hb == 1 && sb == 0) ? 1 : 0;
                    m_b = hb ? 0 : (m_b + 1) % 256;
                end
            end
        end
        m_irq = (mode >= 2'd2) ? (m_lo | m_hi) : m_hi;
        if (mode == 2'd0) m_tgl = m_tgl ^ m_hi;
        else              m_tgl = m_tgl ^ m_lo;
        if (wr_en) begin
            if (wr_sel) m_cb = wr_data;
            else        m_ca = wr_data % 16;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(cur_req, "cnt_lo", cnt_lo, m_a);
        chk(cur_req, "cnt_hi", cnt_hi, m_b);
        chk(cur_req, "match_lo", match_lo, m_lo);
        chk(cur_req, "match_hi", match_hi, m_hi);
        chk(cur_req, "irq", irq, m_irq);
        chk(cur_req, "shift_clk", shift_clk, m_tgl);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(bit sel, int data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data[7:0];
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        rst_n = 1'b0;
        run(3);
        chk("R1", "reset cnt_lo", cnt_lo, 0);
        chk("R1", "reset shift_clk", shift_clk, 0);
        rst_n = 1'b1;
        tick();
        chk("R1", "first cycle match_hi", match_hi, 0);

        // R9: default compare of all ones, then writes with upper bits set on sel 0
        cur_req = "R2";
        mode = 2'd2; en = 1'b1;
        run(40);
        cur_req = "R9";
        wr(1'b0, 8'hA3);
        wr(1'b1, 5);
        run(30);

        // R2 / R8 / R7: split free mode, both encodings
        cur_req = "R2";
        run(40);
        cur_req = "R8";
        mode = 2'd3;
        run(30);
        cur_req = "R7";
        wr(1'b0, 0);
        run(10);
        wr(1'b0, 6);
        run(30);

        // R3: enable gaps
        cur_req = "R3";
        for (int i = 0; i < 30; i++) begin
            en = (i % 3 != 0);
            tick();
        end
        en = 1'b0;
        run(12);
        chk("R3", "idle match_lo", match_lo, 0);
        en = 1'b1;

        // R4: chained mode
        cur_req = "R4";
        mode = 2'd1;
        wr(1'b0, 2);
        wr(1'b1, 3);
        run(60);
        wr(1'b0, 0);
        run(25);

        // R5: joined 12-bit mode
        cur_req = "R5";
        mode = 2'd0;
        wr(1'b0, 5);
        wr(1'b1, 2);
        run(120);
        chk("R5", "joined match_lo", match_lo, 0);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        run(4200);

        // R6: suppression, low stage in split mode
        cur_req = "R6";
        mode = 2'd2;
        wr(1'b0, 4);
        wr(1'b1, 9);
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 40 && m_a != m_ca; i++) tick();
            wr(1'b0, m_ca);
            chk("R6", "suppressed match_lo", match_lo, 0);
            chk("R6", "reload after suppress", cnt_lo, 0);
            run(12);
        end
        // R6: suppression, high stage in split mode
        for (int i = 0; i < 40 && m_b != m_cb; i++) tick();
        wr(1'b1, m_cb);
        chk("R6", "suppressed match_hi", match_hi, 0);
        chk("R6", "hi reload after suppress", cnt_hi, 0);
        run(12);
        // R6: suppression in chained mode blocks the chain step
        mode = 2'd1;
        for (int i = 0; i < 40 && m_a != m_ca; i++) tick();
        wr(1'b0, m_ca);
        chk("R6", "chain not stepped", match_lo, 0);
        run(20);
        // R6: suppression in joined mode through a low-register write
        mode = 2'd0;
        wr(1'b0, 1);
        wr(1'b1, 1);
        for (int i = 0; i < 5000 && !(m_a == m_ca && m_b == m_cb); i++) tick();
        wr(1'b0, m_ca);
        chk("R6", "joined suppressed", match_hi, 0);
        chk("R6", "joined reload", cnt_hi, 0);
        run(40);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule